// File: doc/BRIEF.md
# Memory-Mapped Factorial Engine with Software Interrupt Unit

This block is a small register-mapped peripheral on a word-oriented read/write bus. A processor can read a fixed identification word. It can write a liveness word and read back its bitwise inverse. It can also start a factorial computation and poll a busy flag until the result is ready. Writes take effect on the clock edge. Reads are combinational from the address.

An interrupt unit keeps a 32-bit status word. Bits are set by software through a raise register, by a finished factorial when completion interrupts are enabled, and by a pulse on an external transfer-completion input. Bits are cleared by writing ones to an acknowledge register. A single level output is high whenever any status bit is set.

Top module: `mmio_fact_irq`

## Requirements
- R1: Reading byte offset 0x00 returns the constant ID_VALUE (default 0x5EED0A11), and writes to that offset change nothing.
- R2: Reading offset 0x04 returns the bitwise inverse of the last word written there. After reset, offset 0x04 reads 0xFFFFFFFF.
- R3: Writing N to offset 0x08 starts a computation. Once it is idle, offset 0x08 reads N! modulo 2^32 (10 gives 3628800, 5 gives 120, 13 gives 1932053504), and N of 0 or 1 gives 1.
- R4: Bit 0 of offset 0x20 reads 1 from the cycle after an accepted start until the result is ready, then reads 0.
- R5: A write to offset 0x08 while bit 0 of offset 0x20 is 1 is ignored, and the running result is unaffected.
- R6: Bit 7 of offset 0x20 is a read/write completion-interrupt enable. When it is 1, a finished factorial sets bit 0 of the interrupt status (offset 0x24). When it is 0, a finished factorial sets nothing.
- R7: Writing a word to offset 0x60 ORs it into the interrupt status, and the irq output is then high.
- R8: Writing a word to offset 0x64 clears the status bits where the word has ones. irq stays high while any bit remains set and goes low once the status is zero.
- R9: A one-cycle pulse on xfer_done sets interrupt status bit 8 (0x100).
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x20, 0x24 return zero. This includes the write-only offsets 0x60 and 0x64.
- R11: If an event sets a status bit in the same cycle that an acknowledge write clears it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| xfer_done | input | 1 | Transfer-completion event pulse |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The hardest case to reach from the ports is the collision between an acknowledge write and a new event on the same edge. An ordinary software-style sequence never produces it. The bench drives the xfer_done pulse in the exact cycle of a write that acknowledges bit 8, then checks that the bit survived. Wrapped factorials are reached with N of 13 and with N of 0xFFFFFFFF; the latter must finish quickly because its product becomes zero. The stimulus also aims a second start into the busy window to confirm it is dropped.

// File: rtl/mfi_pkg.sv
// Package: shared register offsets and interrupt bit positions for the
// factorial/interrupt peripheral. Assumes byte offsets on a 32-bit bus.
package mfi_pkg;
    localparam int OFF_ID    = 'h00;
    localparam int OFF_LIVE  = 'h04;
    localparam int OFF_FACT  = 'h08;
    localparam int OFF_CTRL  = 'h20;
    localparam int OFF_IRQST = 'h24;
    localparam int OFF_RAISE = 'h60;
    localparam int OFF_ACK   = 'h64;

    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_IEN_BIT  = 7;
    localparam int EVT_FACT_BIT  = 0;
    localparam int EVT_XFER_BIT  = 8;
endpackage

// File: rtl/mfi_fact_engine.sv
// Module: iterative factorial engine. One multiply per cycle, result modulo
// 2^DATA_W. Assumes start is a single-cycle strobe; a start while busy is
// dropped. Finishes early once the product has become zero.
module mfi_fact_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] n_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] cnt_q;
    logic              finish;

    // Decide whether the remaining factors can change the product.
    always_comb begin
        finish = (cnt_q <= DATA_W'(1)) || (acc_q == '0);
    end

    // Load, step and retire the computation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= DATA_W'(1);
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                acc_q <= DATA_W'(1);
                cnt_q <= n_in;
                busy  <= 1'b1;
            end else if (busy) begin
                if (finish) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    acc_q <= acc_q * cnt_q;
                    cnt_q <= cnt_q - DATA_W'(1);
                end
            end
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/mfi_irq_unit.sv
// Module: interrupt status word. Software raise ORs bits in, acknowledge
// clears the written ones, and internal events set fixed bits. An event wins
// over an acknowledge of the same bit in the same cycle. Assumes raise and
// acknowledge never arrive in the same cycle.
module mfi_irq_unit #(
    parameter int DATA_W   = 32,
    parameter int FACT_BIT = 0,
    parameter int XFER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_we,
    input  logic              ack_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fact_evt,
    input  logic              xfer_evt,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] set_vec;

    // Place internal events on their status bits.
    always_comb begin
        evt_vec           = '0;
        evt_vec[FACT_BIT] = fact_evt;
        evt_vec[XFER_BIT] = xfer_evt;
    end

    // Form the clear and set masks for this cycle.
    always_comb begin
        clr_vec = ack_we   ? wdata : '0;
        set_vec = (raise_we ? wdata : '0) | evt_vec;
    end

    // Update the status word; sets applied after clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    assign irq = |status;
endmodule

// File: rtl/mmio_fact_irq.sv
// Module: top of the peripheral. Decodes writes, holds the liveness word and
// the completion-interrupt enable, and muxes combinational read data.
// Assumes one access per cycle and byte offsets on bus_addr.
module mmio_fact_irq #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h5EED_0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_done,
    output logic              irq
);
    import mfi_pkg::*;

    localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFF_LIVE);
    localparam logic [ADDR_W-1:0] A_FACT  = ADDR_W'(OFF_FACT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_IRQST = ADDR_W'(OFF_IRQST);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFF_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);

    logic [DATA_W-1:0] live_q;
    logic              ien_q;
    logic              fact_busy;
    logic              fact_done;
    logic [DATA_W-1:0] fact_res;
    logic [DATA_W-1:0] irq_status;
    logic              we_live, we_fact, we_ctrl, we_raise, we_ack;

    // Decode the write strobe per register.
    always_comb begin
        we_live  = bus_wr && (bus_addr == A_LIVE);
        we_fact  = bus_wr && (bus_addr == A_FACT);
        we_ctrl  = bus_wr && (bus_addr == A_CTRL);
        we_raise = bus_wr && (bus_addr == A_RAISE);
        we_ack   = bus_wr && (bus_addr == A_ACK);
    end

    // Hold the liveness word and the completion-interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (we_live) live_q <= bus_wdata;
            if (we_ctrl) ien_q  <= bus_wdata[CTRL_IEN_BIT];
        end
    end

    mfi_fact_engine #(.DATA_W(DATA_W)) u_fact (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (we_fact),
        .n_in   (bus_wdata),
        .busy   (fact_busy),
        .done   (fact_done),
        .result (fact_res)
    );

    mfi_irq_unit #(
        .DATA_W   (DATA_W),
        .FACT_BIT (EVT_FACT_BIT),
        .XFER_BIT (EVT_XFER_BIT)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_we (we_raise),
        .ack_we   (we_ack),
        .wdata    (bus_wdata),
        .fact_evt (fact_done && ien_q),
        .xfer_evt (xfer_done),
        .status   (irq_status),
        .irq      (irq)
    );

    // Select read data by offset; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_ID:    bus_rdata = DATA_W'(ID_VALUE);
            A_LIVE:  bus_rdata = ~live_q;
            A_FACT:  bus_rdata = fact_res;
            A_CTRL: begin
                bus_rdata[CTRL_BUSY_BIT] = fact_busy;
                bus_rdata[CTRL_IEN_BIT]  = ien_q;
            end
            A_IRQST: bus_rdata = irq_status;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mfi_checker.sv
// Module: temporal checks for mmio_fact_irq, attached by bind below.
module mfi_checker #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h5EED_0A11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              xfer_done,
    input logic              irq,
    input logic              fact_busy,
    input logic              fact_done
);
    // R1
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h00)) |-> (bus_rdata == DATA_W'(ID_VALUE)));
    // R4
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h08) && !fact_busy) |=> fact_busy);
    // R7
    raise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h60) && bus_wdata != '0) |=> irq);
    // R8
    ack_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h64) && bus_wdata == '1
         && !xfer_done && !fact_done) |=> !irq);
    // R9
    xfer_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> irq);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h10)) |-> (bus_rdata == '0));
endmodule

bind mmio_fact_irq mfi_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ID_VALUE (ID_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .xfer_done (xfer_done),
    .irq       (irq),
    .fact_busy (fact_busy),
    .fact_done (fact_done)
);

// File: tb/mmio_fact_irq_test.sv
module mmio_fact_irq_test;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [31:0] IDV = 32'h5EED_0A11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          xfer_done = 1'b0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_st;

    always #2.5 clk = ~clk;

    mmio_fact_irq #(.ADDR_W(AW), .DATA_W(DW), .ID_VALUE(IDV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .irq(irq)
    );

    function automatic logic [31:0] fact_ref(input logic [31:0] n);
        logic [31:0] acc = 32'd1;
        logic [31:0] k = n;
        while (k > 32'd1 && acc != 32'd0) begin
            acc = acc * k;
            k = k - 32'd1;
        end
        return acc;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input bit with_xfer = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; xfer_done = with_xfer;
        @(negedge clk);
        bus_wr = 1'b0; xfer_done = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd('h20, s);
            if (s[0] == 1'b0) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic run_fact(input logic [31:0] n);
        logic [31:0] v;
        wr('h08, n);
        rd('h20, v);
        chk("R4 busy after start", {31'd0, v[0]}, 32'd1);
        wait_idle();
        rd('h20, v);
        chk("R4 busy cleared", {31'd0, v[0]}, 32'd0);
        rd('h08, v);
        chk("R3 factorial", v, fact_ref(n));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] r;
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd('h00, v); chk("R1 id at reset", v, IDV);
        rd('h04, v); chk("R2 live at reset", v, 32'hFFFF_FFFF);
        rd('h20, v); chk("R4 ctrl at reset", v, 32'd0);
        rd('h24, v); chk("R7 status at reset", v, 32'd0);
        chk("R8 irq at reset", {31'd0, irq}, 32'd0);

        // R1: id write ignored
        wr('h00, 32'h1234_5678);
        rd('h00, v); chk("R1 id after write", v, IDV);

        // R10: unmapped and write-only offsets
        rd('h10, v); chk("R10 unmapped 0x10", v, 32'd0);
        rd('h60, v); chk("R10 raise reads zero", v, 32'd0);
        rd('h64, v); chk("R10 ack reads zero", v, 32'd0);
        rd('hFC, v); chk("R10 unmapped 0xFC", v, 32'd0);

        // R2: liveness inversion, directed and random
        wr('h04, 32'hDEAD_BEEF);
        rd('h04, v); chk("R2 live inverse", v, 32'h2152_4110);
        for (int i = 0; i < 6; i++) begin
            r = $urandom;
            wr('h04, r);
            rd('h04, v); chk("R2 live random", v, ~r);
        end

        // R3/R4: directed corners
        run_fact(32'd10);
        run_fact(32'd5);
        run_fact(32'd0);
        run_fact(32'd1);
        run_fact(32'd13);
        run_fact(32'hFFFF_FFFF);

        // R5: second start inside busy window dropped
        wr('h08, 32'd10);
        wr('h08, 32'd3);
        wait_idle();
        rd('h08, v); chk("R5 start while busy ignored", v, 32'd3628800);

        // R6: completion without enable sets nothing
        rd('h24, v); chk("R6 no event when disabled", v, 32'd0);
        wr('h20, 32'h80);
        rd('h20, v); chk("R6 enable readback", v, 32'h80);
        wr('h08, 32'd5);
        wait_idle();
        rd('h24, v); chk("R6 completion event", v, 32'h1);
        chk("R6 irq on completion", {31'd0, irq}, 32'd1);
        rd('h08, v); chk("R3 factorial 5 with irq", v, 32'd120);
        wr('h64, 32'hFFFF_FFFF);
        rd('h24, v); chk("R8 ack completion", v, 32'd0);

        // R3 random with enable on
        for (int i = 0; i < 8; i++) begin
            r = $urandom_range(40, 0);
            run_fact(r);
            rd('h24, v); chk("R6 event random", v, 32'h1);
            wr('h64, 32'h1);
        end
        wr('h20, 32'h0);

        // R7/R8: raise and partial ack
        wr('h60, 32'hDEAD_BEEF);
        rd('h24, v); chk("R7 raise value", v, 32'hDEAD_BEEF);
        chk("R7 irq high", {31'd0, irq}, 32'd1);
        wr('h64, 32'h0000_FFFF);
        rd('h24, v); chk("R8 partial ack", v, 32'hDEAD_0000);
        chk("R8 irq held", {31'd0, irq}, 32'd1);
        wr('h64, 32'hFFFF_FFFF);
        rd('h24, v); chk("R8 full ack", v, 32'd0);
        chk("R8 irq low", {31'd0, irq}, 32'd0);

        // R9: transfer completion
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        rd('h24, v); chk("R9 xfer bit", v, 32'h100);

        // R11: event and ack of same bit in the same cycle
        wr('h64, 32'h100, 1'b1);
        rd('h24, v); chk("R11 collision keeps bit", v, 32'h100);
        wr('h64, 32'h100);
        rd('h24, v); chk("R8 ack xfer", v, 32'd0);

        // Random raise/ack/xfer mix against a model
        model_st = 32'd0;
        for (int i = 0; i < 30; i++) begin
            int op;
            op = $urandom_range(2, 0);
            r = $urandom;
            if (op == 0) begin
                wr('h60, r); model_st = model_st | r;
            end else if (op == 1) begin
                wr('h64, r); model_st = model_st & ~r;
            end else begin
                @(negedge clk); xfer_done = 1'b1;
                @(negedge clk); xfer_done = 1'b0;
                model_st = model_st | 32'h100;
            end
            rd('h24, v); chk("R7 R8 R9 random status", v, model_st);
            chk("R8 random irq", {31'd0, irq}, {31'd0, model_st != 0});
        end
        finish_run();
    end
endmodule